// File: doc/BRIEF.md
# Predicated Instruction Decoder

This block turns one 16-bit instruction word of a small single-cycle 16-bit CPU into the control signals that steer its datapath. It is purely combinational. It pulls out the operand fields, classifies the opcode, checks the word's single predicate bit against the current zero flag, and drives the write enables, memory strobes, ALU operation, write-back source, a program-counter-written indication and an undefined-instruction flag.

Every instruction can be predicated. If the predicate bit is set and the zero flag is clear, the instruction becomes a no-op: every enable and strobe is held low. A word the decoder does not recognise is also turned into a no-op and is flagged. The decode is fixed; it is not a stream and has no handshake. The surrounding core presents a word and the current zero flag, and it reads the controls back in the same cycle. A write to register code 000 still raises the register write enable. The register file is the part that discards that write.

Top module: `cond_decoder`

## Requirements
- R1: Fields are taken from fixed positions: opcode bits 15..12, predicate bit 11, rd bits 10..8, ra bits 6..4, rb bits 2..0, imm8 bits 7..0.
- R2: Opcodes other than 0000 (low-byte load), 0001 (high-byte set), 0100 (store), 0101 (load), 1000 (add), 1001 (sub), 1010 (and), 1011 (or) raise undef_o, and then reg_we_o, flag_we_o, mem_rd_o, mem_wr_o and pc_wr_o are all 0.
- R3: For register-form opcodes (01xx, 10xx), a 1 in bit 7 or bit 3 raises undef_o with all enables 0. For immediate-form opcodes (000x), bits 7 and 3 are plain immediate data.
- R4: cond_pass_o is 1 when the predicate bit is 0, or when the predicate bit is 1 and zflag_i is 1.
- R5: When cond_pass_o is 0, reg_we_o, flag_we_o, mem_rd_o, mem_wr_o and pc_wr_o are all 0.
- R6: flag_we_o is 1 only for a passing add, sub, and or or. Passing low-byte load, high-byte set, load and store give flag_we_o = 0.
- R7: A passing store gives mem_wr_o=1 and reg_we_o=0. A passing load gives mem_rd_o=1, reg_we_o=1 and wb_sel_o=3 (memory).
- R8: A low-byte load gives imm_ext_o = {8'h00, imm8} and wb_sel_o=1. A high-byte set gives imm_ext_o = {imm8, 8'h00} and wb_sel_o=2, so the datapath can merge it with the low byte of rd.
- R9: ALU opcodes give alu_op_o = 0 (add), 1 (sub), 2 (and), 3 (or) and wb_sel_o = 0 (ALU). A passing ALU opcode also gives reg_we_o=1.
- R10: pc_wr_o is 1 exactly when reg_we_o is 1 and rd is 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word to decode |
| zflag_i | input | 1 | Current zero flag |
| op_o | output | 4 | Opcode field |
| cond_o | output | 1 | Predicate bit |
| rd_o | output | 3 | Destination / store-data register |
| ra_o | output | 3 | First operand / address register |
| rb_o | output | 3 | Second operand register |
| imm8_o | output | 8 | Raw immediate byte |
| imm_ext_o | output | 16 | Immediate placed for write-back |
| cond_pass_o | output | 1 | Predicate satisfied |
| reg_we_o | output | 1 | Register write enable |
| flag_we_o | output | 1 | Flag register update enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| alu_op_o | output | 2 | ALU operation select |
| wb_sel_o | output | 2 | Write-back source select |
| pc_wr_o | output | 1 | Program counter is the write target |
| undef_o | output | 1 | Unrecognised instruction word |

## Verification
All sixteen opcodes are swept. This separates the eight legal classes from the eight undefined ones, and each legal class is checked for its own enable pattern. Every legal opcode is also decoded under all four combinations of predicate bit and zero flag. Only the predicate 1, zero flag 0 case may silence it, and the other three must leave it unchanged. Register-form words with bit 7 or bit 3 set are compared against immediate-form words with the same bits set. This shows that the padding check applies only to register form. Destination 111 is contrasted with other destinations, with stores, and with failing predicates, to pin down when the program-counter-written output is raised.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int WORD_W = 16;
  localparam int OP_W   = 4;
  localparam int RSEL_W = 3;
  localparam int IMM_W  = 8;

  localparam logic [OP_W-1:0] OPC_MOVL = 4'b0000;
  localparam logic [OP_W-1:0] OPC_SETH = 4'b0001;
  localparam logic [OP_W-1:0] OPC_STR  = 4'b0100;
  localparam logic [OP_W-1:0] OPC_LDR  = 4'b0101;
  localparam logic [OP_W-1:0] OPC_ADD  = 4'b1000;
  localparam logic [OP_W-1:0] OPC_SUB  = 4'b1001;
  localparam logic [OP_W-1:0] OPC_AND  = 4'b1010;
  localparam logic [OP_W-1:0] OPC_ORR  = 4'b1011;

  localparam logic [RSEL_W-1:0] REG_PC = 3'b111;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_ORR = 2'd3
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_LOW  = 2'd1,
    WB_HIGH = 2'd2,
    WB_MEM  = 2'd3
  } wb_sel_e;

  typedef struct packed {
    logic    is_movl;
    logic    is_seth;
    logic    is_str;
    logic    is_ldr;
    logic    is_alu;
    logic    bad;
    alu_op_e alu_op;
    wb_sel_e wb_sel;
  } op_class_t;
endpackage

// File: rtl/dec_fields.sv
module dec_fields
  import dec_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0]      word_i,
  output logic [OP_W-1:0]   op_o,
  output logic              cond_o,
  output logic [RSEL_W-1:0] rd_o,
  output logic [RSEL_W-1:0] ra_o,
  output logic [RSEL_W-1:0] rb_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic              pad_nz_o
);
  localparam int OP_LSB   = W - OP_W;
  localparam int COND_BIT = OP_LSB - 1;
  localparam int RD_LSB   = COND_BIT - RSEL_W;
  localparam int PAD_HI   = RD_LSB - 1;
  localparam int RA_LSB   = PAD_HI - RSEL_W;
  localparam int PAD_LO   = RA_LSB - 1;
  localparam int RB_LSB   = PAD_LO - RSEL_W;

  always_comb begin
    op_o     = word_i[OP_LSB +: OP_W];
    cond_o   = word_i[COND_BIT];
    rd_o     = word_i[RD_LSB +: RSEL_W];
    ra_o     = word_i[RA_LSB +: RSEL_W];
    rb_o     = word_i[RB_LSB +: RSEL_W];
    imm_o    = word_i[IMM_W-1:0];
    pad_nz_o = word_i[PAD_HI] | word_i[PAD_LO];
  end
endmodule

// File: rtl/dec_classify.sv
module dec_classify
  import dec_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic            pad_nz_i,
  output op_class_t       cls_o
);
  logic reg_form;

  always_comb begin
    cls_o          = '0;
    cls_o.alu_op   = ALU_ADD;
    cls_o.wb_sel   = WB_ALU;
    reg_form       = 1'b0;
    unique case (op_i)
      OPC_MOVL: begin cls_o.is_movl = 1'b1; cls_o.wb_sel = WB_LOW;  end
      OPC_SETH: begin cls_o.is_seth = 1'b1; cls_o.wb_sel = WB_HIGH; end
      OPC_STR:  begin cls_o.is_str  = 1'b1; reg_form = 1'b1; end
      OPC_LDR:  begin cls_o.is_ldr  = 1'b1; reg_form = 1'b1; cls_o.wb_sel = WB_MEM; end
      OPC_ADD, OPC_SUB, OPC_AND, OPC_ORR: begin
        cls_o.is_alu = 1'b1;
        reg_form     = 1'b1;
        cls_o.alu_op = alu_op_e'(op_i[1:0]);
      end
      default: cls_o.bad = 1'b1;
    endcase
    if (reg_form && pad_nz_i) cls_o.bad = 1'b1;
  end
endmodule

// File: rtl/dec_cond.sv
module dec_cond (
  input  logic cond_i,
  input  logic zflag_i,
  output logic pass_o
);
  always_comb pass_o = (~cond_i) | zflag_i;
endmodule

// File: rtl/cond_decoder.sv
module cond_decoder
  import dec_pkg::*;
(
  input  logic [15:0] instr_i,
  input  logic        zflag_i,
  output logic [3:0]  op_o,
  output logic        cond_o,
  output logic [2:0]  rd_o,
  output logic [2:0]  ra_o,
  output logic [2:0]  rb_o,
  output logic [7:0]  imm8_o,
  output logic [15:0] imm_ext_o,
  output logic        cond_pass_o,
  output logic        reg_we_o,
  output logic        flag_we_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic [1:0]  alu_op_o,
  output logic [1:0]  wb_sel_o,
  output logic        pc_wr_o,
  output logic        undef_o
);
  localparam int HI_W = WORD_W - IMM_W;

  logic      pad_nz;
  logic      pass;
  logic      go;
  op_class_t cls;

  dec_fields #(.W(WORD_W)) u_fields (
    .word_i   (instr_i),
    .op_o     (op_o),
    .cond_o   (cond_o),
    .rd_o     (rd_o),
    .ra_o     (ra_o),
    .rb_o     (rb_o),
    .imm_o    (imm8_o),
    .pad_nz_o (pad_nz)
  );

  dec_classify u_class (
    .op_i     (op_o),
    .pad_nz_i (pad_nz),
    .cls_o    (cls)
  );

  dec_cond u_cond (
    .cond_i  (cond_o),
    .zflag_i (zflag_i),
    .pass_o  (pass)
  );

  always_comb begin
    go          = pass & ~cls.bad;
    cond_pass_o = pass;
    undef_o     = cls.bad;
    reg_we_o    = go & (cls.is_movl | cls.is_seth | cls.is_ldr | cls.is_alu);
    flag_we_o   = go & cls.is_alu;
    mem_rd_o    = go & cls.is_ldr;
    mem_wr_o    = go & cls.is_str;
    pc_wr_o     = reg_we_o & (rd_o == REG_PC);
    alu_op_o    = cls.alu_op;
    wb_sel_o    = cls.wb_sel;
    if (cls.is_seth)      imm_ext_o = {imm8_o, {HI_W{1'b0}}};
    else if (cls.is_movl) imm_ext_o = {{HI_W{1'b0}}, imm8_o};
    else                  imm_ext_o = '0;
  end
endmodule

// File: rtl/cond_decoder_chk.sv
module cond_decoder_chk (
  input logic [15:0] instr_i,
  input logic        zflag_i,
  input logic        cond_pass_o,
  input logic        reg_we_o,
  input logic        flag_we_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        pc_wr_o,
  input logic        undef_o,
  input logic [2:0]  rd_o
);
  always_comb begin
    if (undef_o)
      assert_undef_silent_R2: assert (!(reg_we_o | flag_we_o | mem_rd_o | mem_wr_o | pc_wr_o));
    if (instr_i[11] && !zflag_i)
      assert_fail_silent_R5: assert (!(reg_we_o | flag_we_o | mem_rd_o | mem_wr_o | pc_wr_o));
    if (flag_we_o)
      assert_flag_alu_only_R6: assert (instr_i[15:14] == 2'b10 && reg_we_o);
    if (mem_wr_o)
      assert_store_no_reg_R7: assert (!reg_we_o && !mem_rd_o && !flag_we_o);
    if (pc_wr_o)
      assert_pc_needs_write_R10: assert (reg_we_o && rd_o == 3'b111 && cond_pass_o);
    if (instr_i[15:13] == 3'b000)
      assert_imm_form_defined_R3: assert (!undef_o);
  end
endmodule

bind cond_decoder cond_decoder_chk u_chk (
  .instr_i     (instr_i),
  .zflag_i     (zflag_i),
  .cond_pass_o (cond_pass_o),
  .reg_we_o    (reg_we_o),
  .flag_we_o   (flag_we_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .pc_wr_o     (pc_wr_o),
  .undef_o     (undef_o),
  .rd_o        (rd_o)
);

// File: tb/tb_cond_decoder.sv
module tb_cond_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr_i = 16'h0000;
  logic        zflag_i = 1'b0;
  logic [3:0]  op_o;
  logic        cond_o;
  logic [2:0]  rd_o, ra_o, rb_o;
  logic [7:0]  imm8_o;
  logic [15:0] imm_ext_o;
  logic        cond_pass_o, reg_we_o, flag_we_o, mem_rd_o, mem_wr_o;
  logic [1:0]  alu_op_o, wb_sel_o;
  logic        pc_wr_o, undef_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cond_decoder dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w, input logic z);
    @(negedge clk);
    instr_i = w;
    zflag_i = z;
    #2;
  endtask

  function automatic logic [15:0] mk(input logic [3:0] op, input logic c, input logic [2:0] rd,
                                     input logic [7:0] low);
    return {op, c, rd, low};
  endfunction

  function automatic int enables();
    return {27'd0, reg_we_o, flag_we_o, mem_rd_o, mem_wr_o, pc_wr_o};
  endfunction

  task automatic t_reset_word();
    put(16'h0000, 1'b0);
    chk("R8", "nop undef", undef_o, 0);
    chk("R8", "nop imm_ext", imm_ext_o, 0);
    chk("R8", "nop wb", wb_sel_o, 1);
  endtask

  task automatic t_fields();
    put(16'b1001_1_101_0_011_0_110, 1'b1);
    chk("R1", "op", op_o, 4'b1001);
    chk("R1", "cond", cond_o, 1);
    chk("R1", "rd", rd_o, 5);
    chk("R1", "ra", ra_o, 3);
    chk("R1", "rb", rb_o, 6);
    chk("R1", "imm8", imm8_o, 8'h36);
  endtask

  task automatic t_opcode_sweep();
    for (int o = 0; o < 16; o++) begin
      logic legal;
      legal = (o == 0) || (o == 1) || (o == 4) || (o == 5) || (o >= 8 && o <= 11);
      put(mk(4'(o), 1'b0, 3'd2, 8'h12), 1'b0);
      chk("R2", $sformatf("undef op %0d", o), undef_o, legal ? 0 : 1);
      if (!legal) chk("R2", $sformatf("enables op %0d", o), enables(), 0);
    end
  endtask

  task automatic t_padding();
    put(mk(4'b1000, 1'b0, 3'd1, 8'h80 | 8'h21), 1'b1);
    chk("R3", "bit7 alu undef", undef_o, 1);
    chk("R3", "bit7 alu enables", enables(), 0);
    put(mk(4'b0100, 1'b0, 3'd1, 8'h28), 1'b1);
    chk("R3", "bit3 str undef", undef_o, 1);
    chk("R3", "bit3 str enables", enables(), 0);
    put(mk(4'b0000, 1'b0, 3'd1, 8'h88), 1'b0);
    chk("R3", "movl pad bits legal", undef_o, 0);
    chk("R3", "movl pad bits reg_we", reg_we_o, 1);
  endtask

  task automatic t_predicate();
    logic [3:0] ops [8] = '{4'd0, 4'd1, 4'd4, 4'd5, 4'd8, 4'd9, 4'd10, 4'd11};
    foreach (ops[i]) begin
      for (int k = 0; k < 4; k++) begin
        logic c, z;
        c = k[1];
        z = k[0];
        put(mk(ops[i], c, 3'd3, 8'h12), z);
        chk("R4", $sformatf("pass op %0d c%0d z%0d", ops[i], c, z), cond_pass_o, (c && !z) ? 0 : 1);
        if (c && !z) chk("R5", $sformatf("quiet op %0d", ops[i]), enables(), 0);
        else chk("R5", $sformatf("acts op %0d", ops[i]), (reg_we_o | mem_wr_o), 1);
      end
    end
  endtask

  task automatic t_flags();
    for (int o = 8; o < 12; o++) begin
      put(mk(4'(o), 1'b0, 3'd4, 8'h12), 1'b0);
      chk("R6", $sformatf("flag_we alu %0d", o), flag_we_o, 1);
      chk("R9", $sformatf("alu_op %0d", o), alu_op_o, o - 8);
      chk("R9", $sformatf("wb alu %0d", o), wb_sel_o, 0);
      chk("R9", $sformatf("reg_we alu %0d", o), reg_we_o, 1);
    end
    put(mk(4'd0, 1'b0, 3'd4, 8'h12), 1'b0);  chk("R6", "movl no flags", flag_we_o, 0);
    put(mk(4'd1, 1'b0, 3'd4, 8'h12), 1'b0);  chk("R6", "seth no flags", flag_we_o, 0);
    put(mk(4'd5, 1'b0, 3'd4, 8'h12), 1'b0);  chk("R6", "ldr no flags", flag_we_o, 0);
    put(mk(4'd4, 1'b0, 3'd4, 8'h12), 1'b0);  chk("R6", "str no flags", flag_we_o, 0);
  endtask

  task automatic t_memory();
    put(mk(4'd4, 1'b0, 3'd2, 8'h30), 1'b0);
    chk("R7", "str mem_wr", mem_wr_o, 1);
    chk("R7", "str reg_we", reg_we_o, 0);
    chk("R7", "str mem_rd", mem_rd_o, 0);
    put(mk(4'd5, 1'b0, 3'd2, 8'h30), 1'b0);
    chk("R7", "ldr mem_rd", mem_rd_o, 1);
    chk("R7", "ldr reg_we", reg_we_o, 1);
    chk("R7", "ldr wb", wb_sel_o, 3);
    chk("R7", "ldr mem_wr", mem_wr_o, 0);
  endtask

  task automatic t_immediates();
    put(mk(4'd0, 1'b0, 3'd1, 8'hA5), 1'b0);
    chk("R8", "movl imm_ext", imm_ext_o, 16'h00A5);
    chk("R8", "movl wb", wb_sel_o, 1);
    put(mk(4'd1, 1'b0, 3'd1, 8'hC3), 1'b0);
    chk("R8", "seth imm_ext", imm_ext_o, 16'hC300);
    chk("R8", "seth wb", wb_sel_o, 2);
  endtask

  task automatic t_pc_target();
    put(mk(4'd0, 1'b0, 3'd7, 8'h40), 1'b0);
    chk("R10", "movl pc", pc_wr_o, 1);
    put(mk(4'd8, 1'b0, 3'd7, 8'h12), 1'b0);
    chk("R10", "add pc", pc_wr_o, 1);
    put(mk(4'd4, 1'b0, 3'd7, 8'h10), 1'b0);
    chk("R10", "str rd7 no pc", pc_wr_o, 0);
    put(mk(4'd0, 1'b1, 3'd7, 8'h40), 1'b0);
    chk("R10", "failed jump no pc", pc_wr_o, 0);
    put(mk(4'd0, 1'b1, 3'd7, 8'h40), 1'b1);
    chk("R10", "taken jump pc", pc_wr_o, 1);
    put(mk(4'd0, 1'b0, 3'd6, 8'h40), 1'b0);
    chk("R10", "rd6 no pc", pc_wr_o, 0);
    put(mk(4'd5, 1'b0, 3'd7, 8'h88), 1'b0);
    chk("R10", "undef ldr rd7 no pc", pc_wr_o, 0);
  endtask

  initial begin : watchdog
    #1_500_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_word();
    t_fields();
    t_opcode_sweep();
    t_padding();
    t_predicate();
    t_flags();
    t_memory();
    t_immediates();
    t_pc_target();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule